// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block holds the control and status word of a floating-point unit. Software loads and reads the word. The arithmetic units report each finished operation as a five-bit exception vector with a strobe. From each report the register rewrites its flag field, accumulates the cause field, and compares the accumulated causes against the enable field. When a cause is enabled, a one-cycle trap request is raised with a fixed exception code.

The register also decodes two controls for the arithmetic units. The two-bit rounding field selects either round-to-zero or round-to-nearest-even. The denormal bit selects flush-to-zero. A compare port keeps the compare-result bit. An ordered compare loads that bit. An unordered compare leaves the bit unchanged and reports its exceptions through the status path instead.

The word layout is as follows:
- Rounding mode in bits [1:0].
- Flags in bits [6:2].
- Enables in bits [11:7].
- Causes in bits [16:12].
- Denormal control in bit 18.

Inside each five-bit field, bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid. The exception vector input uses the same order.

Top module: `fpu_status_reg`

## Requirements
- R1: After reset, rdData is 0, tBit is 0, trapReq is 0 and trapCode is 0.
- R2: A software write (swWe) stores swData masked to bits [16:0] and bit 18, so that bit 17 and bits [31:19] always read as 0. The read takes effect the cycle after the write.
- R3: rtzSel is 1 exactly when rdData[1:0] is 2'b01. Every other rounding encoding gives rtzSel = 0.
- R4: ftzSel is 1 exactly when rdData[18] is 1.
- R5: An operation report replaces the flag field rdData[6:2] with opExc, which clears any flag the report does not carry. An operation report is opValid, or cmpValid together with cmpUnord.
- R6: A report with nonzero opExc ORs opExc into the cause field rdData[16:12]. A report with opExc = 0 leaves the cause field unchanged. The cause field is never cleared except by a software write.
- R7: A report with nonzero opExc for which (cause | opExc) & enable rdData[11:7] is nonzero raises trapReq for exactly the next cycle, with trapCode = 12'h120. trapCode is 0 whenever trapReq is 0.
- R8: A report with opExc = 0 never raises trapReq, even when the stored cause and enable fields overlap.
- R9: An ordered compare (cmpValid with cmpUnord = 0) loads tBit from cmpResult and leaves rdData unchanged. An unordered compare leaves tBit unchanged and updates the status as an operation report.
- R10: When a software write and an operation report occur in the same cycle, the software write alone takes effect and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swWe | input | 1 | Software write strobe |
| swData | input | 32 | Software write data |
| rdData | output | 32 | Current status and control word |
| opValid | input | 1 | Operation result strobe |
| opExc | input | 5 | Exception vector {invalid, div-by-zero, overflow, underflow, inexact} |
| cmpValid | input | 1 | Compare result strobe |
| cmpUnord | input | 1 | Compare was unordered |
| cmpResult | input | 1 | Ordered compare outcome |
| tBit | output | 1 | Compare-result bit |
| rtzSel | output | 1 | Round-to-zero select |
| ftzSel | output | 1 | Flush-to-zero select |
| trapReq | output | 1 | One-cycle trap request |
| trapCode | output | 12 | Exception code while trapReq is high |

## Verification
The hardest case to reach is a trap caused by a cause bit left over from an earlier operation. In that case the exception that triggers the trap is not itself enabled. The stimulus first builds the condition: it loads an enable bit, then reports that exception so the cause bit becomes sticky. It then reports a clean operation, which must not trap, and after that a different, unenabled exception, which must trap. The collision of a software write with an enabled exception in the same cycle is driven directly, to show that the write wins and that the trap is suppressed.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int REG_W     = 32;
  localparam int EXC_W     = 5;
  localparam int RM_W      = 2;
  localparam int CODE_W    = 12;
  localparam int RM_LSB    = 0;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = FLAG_LSB + EXC_W;
  localparam int CAUSE_LSB = EN_LSB + EXC_W;
  localparam int DN_BIT    = 18;
  localparam logic [RM_W-1:0]   RM_RTZ    = 2'b01;
  localparam logic [CODE_W-1:0] TRAP_CODE = 12'h120;

  function automatic logic [REG_W-1:0] fieldMask(int lsb, int width);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < width; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] WR_MASK =
    fieldMask(RM_LSB, RM_W) | fieldMask(FLAG_LSB, EXC_W) |
    fieldMask(EN_LSB, EXC_W) | fieldMask(CAUSE_LSB, EXC_W) |
    fieldMask(DN_BIT, 1);

  typedef struct packed {
    logic swLoad;
    logic opLoad;
    logic causeAcc;
    logic tLoad;
  } fpsrStrobe_t;
endpackage

// File: rtl/fpsrCtrl.sv
module fpsrCtrl
  import fpsr_pkg::*;
#(
  parameter int EXC_N  = EXC_W,
  parameter int CODE_N = CODE_W,
  parameter logic [CODE_N-1:0] CODE_VAL = TRAP_CODE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWe,
  input  logic              opValid,
  input  logic              cmpValid,
  input  logic              cmpUnord,
  input  logic [EXC_N-1:0]  opExc,
  input  logic              trapHit,
  output fpsrStrobe_t       strb,
  output logic              trapReq,
  output logic [CODE_N-1:0] trapCode
);
  logic opEvent;
  logic anyExc;

  always_comb begin
    opEvent       = opValid | (cmpValid & cmpUnord);
    anyExc        = |opExc;
    strb.swLoad   = swWe;
    strb.opLoad   = opEvent & ~swWe;
    strb.causeAcc = opEvent & ~swWe & anyExc;
    strb.tLoad    = cmpValid & ~cmpUnord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trapReq <= 1'b0;
    else       trapReq <= strb.causeAcc & trapHit;
  end

  assign trapCode = trapReq ? CODE_VAL : '0;
endmodule

// File: rtl/fpsrDatapath.sv
module fpsrDatapath
  import fpsr_pkg::*;
#(
  parameter int DATA_N = REG_W,
  parameter int EXC_N  = EXC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpsrStrobe_t       strb,
  input  logic [DATA_N-1:0] swData,
  input  logic [EXC_N-1:0]  opExc,
  input  logic              cmpResult,
  output logic [DATA_N-1:0] rdData,
  output logic              tBit,
  output logic              rtzSel,
  output logic              ftzSel,
  output logic              trapHit
);
  logic [RM_W-1:0]  rmQ;
  logic [EXC_N-1:0] flagQ;
  logic [EXC_N-1:0] enQ;
  logic [EXC_N-1:0] causeQ;
  logic             dnQ;
  logic [DATA_N-1:0] wrVal;

  assign wrVal = swData & WR_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rmQ    <= '0;
      flagQ  <= '0;
      enQ    <= '0;
      causeQ <= '0;
      dnQ    <= 1'b0;
    end else if (strb.swLoad) begin
      rmQ    <= wrVal[RM_LSB +: RM_W];
      flagQ  <= wrVal[FLAG_LSB +: EXC_N];
      enQ    <= wrVal[EN_LSB +: EXC_N];
      causeQ <= wrVal[CAUSE_LSB +: EXC_N];
      dnQ    <= wrVal[DN_BIT];
    end else begin
      if (strb.opLoad)   flagQ  <= opExc;
      if (strb.causeAcc) causeQ <= causeQ | opExc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           tBit <= 1'b0;
    else if (strb.tLoad) tBit <= cmpResult;
  end

  always_comb begin
    rdData = '0;
    rdData[RM_LSB +: RM_W]      = rmQ;
    rdData[FLAG_LSB +: EXC_N]   = flagQ;
    rdData[EN_LSB +: EXC_N]     = enQ;
    rdData[CAUSE_LSB +: EXC_N]  = causeQ;
    rdData[DN_BIT]              = dnQ;
  end

  assign rtzSel  = (rmQ == RM_RTZ);
  assign ftzSel  = dnQ;
  assign trapHit = |((causeQ | opExc) & enQ);
endmodule

// File: rtl/fpu_status_reg.sv
module fpu_status_reg
  import fpsr_pkg::*;
#(
  parameter int DATA_N = REG_W,
  parameter int EXC_N  = EXC_W,
  parameter int CODE_N = CODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWe,
  input  logic [DATA_N-1:0] swData,
  output logic [DATA_N-1:0] rdData,
  input  logic              opValid,
  input  logic [EXC_N-1:0]  opExc,
  input  logic              cmpValid,
  input  logic              cmpUnord,
  input  logic              cmpResult,
  output logic              tBit,
  output logic              rtzSel,
  output logic              ftzSel,
  output logic              trapReq,
  output logic [CODE_N-1:0] trapCode
);
  fpsrStrobe_t strb;
  logic        trapHit;

  fpsrCtrl #(.EXC_N(EXC_N), .CODE_N(CODE_N), .CODE_VAL(CODE_N'(TRAP_CODE))) u_ctrl (
    .clk(clk), .rstN(rstN), .swWe(swWe), .opValid(opValid),
    .cmpValid(cmpValid), .cmpUnord(cmpUnord), .opExc(opExc),
    .trapHit(trapHit), .strb(strb), .trapReq(trapReq), .trapCode(trapCode)
  );

  fpsrDatapath #(.DATA_N(DATA_N), .EXC_N(EXC_N)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .swData(swData), .opExc(opExc),
    .cmpResult(cmpResult), .rdData(rdData), .tBit(tBit),
    .rtzSel(rtzSel), .ftzSel(ftzSel), .trapHit(trapHit)
  );
endmodule

// File: rtl/fpsrChecker.sv
module fpsrChecker
  import fpsr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              swWe,
  input logic [REG_W-1:0]  swData,
  input logic [REG_W-1:0]  rdData,
  input logic              opValid,
  input logic [EXC_W-1:0]  opExc,
  input logic              cmpValid,
  input logic              cmpUnord,
  input logic              tBit,
  input logic              trapReq,
  input logic [CODE_W-1:0] trapCode
);
  logic opEvent;
  assign opEvent = opValid | (cmpValid & cmpUnord);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~WR_MASK) == '0); // R2
  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rstN)
    swWe |=> rdData == $past(swData & WR_MASK)); // R10
  AST_FLAGS_REWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opEvent && !swWe) |=> rdData[FLAG_LSB +: EXC_W] == $past(opExc)); // R5
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !swWe |=> (rdData[CAUSE_LSB +: EXC_W] & $past(rdData[CAUSE_LSB +: EXC_W]))
              == $past(rdData[CAUSE_LSB +: EXC_W])); // R6
  AST_TRAP_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> ($past(opEvent) && !$past(swWe) && $past(opExc) != '0)); // R7
  AST_TRAP_CODE: assert property (@(posedge clk) disable iff (!rstN)
    trapCode == (trapReq ? TRAP_CODE : '0)); // R7
  AST_NO_TRAP_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (opEvent && opExc == '0) |=> !trapReq); // R8
  AST_T_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && cmpUnord) |=> $stable(tBit)); // R9
endmodule

bind fpu_status_reg fpsrChecker u_fpsrChecker (
  .clk(clk), .rstN(rstN), .swWe(swWe), .swData(swData), .rdData(rdData),
  .opValid(opValid), .opExc(opExc), .cmpValid(cmpValid), .cmpUnord(cmpUnord),
  .tBit(tBit), .trapReq(trapReq), .trapCode(trapCode)
);

// File: tb/test_fpu_status_reg.sv
module test_fpu_status_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swWe = 1'b0;
  logic [31:0] swData = '0;
  logic [31:0] rdData;
  logic        opValid = 1'b0;
  logic [4:0]  opExc = '0;
  logic        cmpValid = 1'b0;
  logic        cmpUnord = 1'b0;
  logic        cmpResult = 1'b0;
  logic        tBit, rtzSel, ftzSel, trapReq;
  logic [11:0] trapCode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_status_reg i_fpu_status_reg (
    .clk(clk), .rstN(rstN), .swWe(swWe), .swData(swData), .rdData(rdData),
    .opValid(opValid), .opExc(opExc), .cmpValid(cmpValid), .cmpUnord(cmpUnord),
    .cmpResult(cmpResult), .tBit(tBit), .rtzSel(rtzSel), .ftzSel(ftzSel),
    .trapReq(trapReq), .trapCode(trapCode)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(logic [1:0] rm, logic [4:0] fl, logic [4:0] en,
                                       logic [4:0] ca, logic dn);
    return {13'd0, dn, 1'b0, ca, en, fl, rm};
  endfunction

  // drive at negedge, sample 1 time unit after the following posedge
  task automatic stepCycle();
    @(posedge clk); #1;
  endtask

  task automatic swWrite(logic [31:0] d);
    @(negedge clk); swWe = 1'b1; swData = d;
    stepCycle();
    @(negedge clk); swWe = 1'b0;
  endtask

  task automatic opReport(logic [4:0] e);
    @(negedge clk); opValid = 1'b1; opExc = e;
    stepCycle();
  endtask

  task automatic idle();
    @(negedge clk); opValid = 1'b0; opExc = '0; cmpValid = 1'b0; cmpUnord = 1'b0; swWe = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 rdData", rdData, 32'h0);
    chk("R1 tBit", {31'd0, tBit}, 32'h0);
    chk("R1 trapReq", {31'd0, trapReq}, 32'h0);
    chk("R1 trapCode", {20'd0, trapCode}, 32'h0);
  endtask

  task automatic testMask();
    swWrite(32'hFFFF_FFFF);
    chk("R2 masked write", rdData, 32'h0005_FFFF);
    chk("R4 ftz on", {31'd0, ftzSel}, 32'h1);
    chk("R3 rm=11 not rtz", {31'd0, rtzSel}, 32'h0);
    swWrite(32'h0002_0000);
    chk("R2 bit17 dropped", rdData, 32'h0);
    chk("R4 ftz off", {31'd0, ftzSel}, 32'h0);
  endtask

  task automatic testRounding();
    for (int r = 0; r < 4; r++) begin
      swWrite(word(r[1:0], 5'd0, 5'd0, 5'd0, 1'b0));
      chk("R3 rounding decode", {31'd0, rtzSel}, {31'd0, (r == 1)});
    end
  endtask

  task automatic testFlagsCause();
    swWrite(32'h0);
    opReport(5'b10001);
    chk("R5 flags V|I", rdData, word(2'b00, 5'b10001, 5'd0, 5'b10001, 1'b0));
    opReport(5'b00100);
    chk("R5 R6 flags O, cause grows", rdData, word(2'b00, 5'b00100, 5'd0, 5'b10101, 1'b0));
    opReport(5'b00000);
    chk("R6 clean op clears flags only", rdData, word(2'b00, 5'b00000, 5'd0, 5'b10101, 1'b0));
    chk("R8 no trap without enables", {31'd0, trapReq}, 32'h0);
    idle();
  endtask

  task automatic testTrap();
    swWrite(word(2'b00, 5'd0, 5'b01000, 5'd0, 1'b0));
    opReport(5'b01000);
    chk("R7 trap raised", {31'd0, trapReq}, 32'h1);
    chk("R7 trap code", {20'd0, trapCode}, 32'h120);
    idle();
    stepCycle();
    chk("R7 trap one cycle", {31'd0, trapReq}, 32'h0);
    chk("R7 code cleared", {20'd0, trapCode}, 32'h0);
    opReport(5'b00000);
    chk("R8 clean op no trap", {31'd0, trapReq}, 32'h0);
    opReport(5'b00001);
    chk("R7 sticky cause traps on unenabled exc", {31'd0, trapReq}, 32'h1);
    idle();
    stepCycle();
  endtask

  task automatic testCompare();
    swWrite(32'h0);
    @(negedge clk); cmpValid = 1'b1; cmpUnord = 1'b0; cmpResult = 1'b1;
    stepCycle();
    chk("R9 ordered loads tBit", {31'd0, tBit}, 32'h1);
    chk("R9 ordered leaves status", rdData, 32'h0);
    @(negedge clk); cmpUnord = 1'b1; cmpResult = 1'b0; opExc = 5'b10000;
    stepCycle();
    chk("R9 unordered keeps tBit", {31'd0, tBit}, 32'h1);
    chk("R9 unordered updates status", rdData, word(2'b00, 5'b10000, 5'd0, 5'b10000, 1'b0));
    idle();
  endtask

  task automatic testCollision();
    swWrite(word(2'b00, 5'd0, 5'b11111, 5'd0, 1'b0));
    @(negedge clk); swWe = 1'b1; swData = word(2'b01, 5'd0, 5'b11111, 5'd0, 1'b0);
    opValid = 1'b1; opExc = 5'b00010;
    stepCycle();
    chk("R10 write wins", rdData, word(2'b01, 5'd0, 5'b11111, 5'd0, 1'b0));
    chk("R10 no trap", {31'd0, trapReq}, 32'h0);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk); rstN = 1'b1;
    testMask();
    testRounding();
    testFlagsCause();
    testTrap();
    testCompare();
    testCollision();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule